// File: doc/BRIEF.md
# Transmit Byte Buffer with Underrun Replay

This block sits between a processor write port and a byte-serial shifter. Software pushes data in as whole 16-bit words or as single bytes. Byte writes are paired into a word before they are stored. The shifter pulls one byte per request, low half first, and the block returns that byte on the following cycle. Each of the eight 16-bit entries carries an occupied bit. The bit is set when the entry is completed and cleared when its high byte has been handed out.

When the shifter asks for a byte from an entry that holds no fresh data, the block does not stall. It returns whatever the entry still holds, steps its read position forward as usual, and raises a sticky underrun status bit. A second sticky status bit reports that enough 16-bit slots are empty to accept more data. The slot count is chosen as 1, 2 or 4. Both status bits are cleared by writing ones, and each one is gated by its own mask bit onto a single interrupt line.

Top module: `tx_fifo_uflow`

## Requirements
- R1: After reset `free_cnt` reads 8, `full` is 0, both status bits are 0 and `irq_o` is 0. `free_cnt` always equals 8 minus the number of occupied entries.
- R2: A word write (`cpu_wr_word`=1) stores `cpu_wr_data` as one entry and lowers `free_cnt` by one. The shifter receives bits 7:0 first and bits 15:8 second. The entry is released only after the second byte.
- R3: With `cpu_wr_word`=0, a first byte write (data in bits 7:0) leaves `free_cnt` unchanged. A second byte write completes the entry, with the earlier byte as the low half and the later byte as the high half.
- R4: A word write made while a single byte is waiting for its partner discards that byte and stores the whole word. The next byte write starts a fresh pair.
- R5: `full` is 1 while the entry at the write position is still occupied, which after in-order use means all 8 entries are occupied. A write of either size made while `full` is 1 changes no stored data and no count.
- R6: Status bit 0 (threshold) is set in a cycle when `free_cnt` is at least N. `thr_sel` gives N: 00 selects 1, 01 selects 2, 10 selects 4, and 11 is treated as 4.
- R7: A shift request made while the entry at the read position is not occupied sets status bit 1 (underrun). The stale byte held there is still returned, and the read position advances exactly as for a normal read.
- R8: Status bits stay set until a 1 is written to the matching bit of `sts_clr`. If the same bit is set again in that cycle, the set wins.
- R9: `irq_o` is the OR of `irq_sts & irq_mask` and follows it one cycle later. Bit 0 masks the threshold status and bit 1 masks the underrun status.
- R10: The byte for a shift request appears on `shf_byte` in the cycle after the request and is held until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | Processor write strobe |
| cpu_wr_word | input | 1 | 1 for a 16-bit write, 0 for a byte write |
| cpu_wr_data | input | 16 | Write data; byte writes use bits 7:0 |
| shf_rd_req | input | 1 | Shifter request for the next byte |
| shf_byte | output | 8 | Byte returned for the previous request |
| thr_sel | input | 2 | Threshold select for the free-slot interrupt |
| irq_mask | input | 2 | Interrupt enables: bit 0 threshold, bit 1 underrun |
| sts_clr | input | 2 | Write-one-to-clear strobes for the status bits |
| irq_sts | output | 2 | Sticky status: bit 0 threshold, bit 1 underrun |
| irq_o | output | 1 | Masked interrupt request |
| full | output | 1 | Slot at the write position is still occupied |
| free_cnt | output | 4 | Number of empty 16-bit entries |

## Verification
The assertions assume that every input is a clean 0 or 1 at each clock edge. They assume that `sts_clr` is the only route by which a status bit falls, and that the underrun bit is raised only in a cycle that carries a shift request. No assumption limits when writes and requests occur. The stimulus therefore lets both come in any cycle, including while the buffer is full or empty, and lets `thr_sel`, `irq_mask` and `sts_clr` change from cycle to cycle. The underrun bit must be able to appear even after pointer positions drift apart. For that reason the stimulus first writes every entry once, so that stale replays return known data.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic [1:0] {
    THR_ONE  = 2'b00,
    THR_TWO  = 2'b01,
    THR_FOUR = 2'b10,
    THR_RSVD = 2'b11
  } thr_sel_e;

  localparam int ST_THR = 0;
  localparam int ST_UND = 1;
  localparam int ST_W   = 2;

  // number of empty 16-bit slots demanded by a threshold code
  function automatic int thr_words(input logic [1:0] sel);
    case (thr_sel_e'(sel))
      THR_ONE:  return 1;
      THR_TWO:  return 2;
      default:  return 4;
    endcase
  endfunction
endpackage

// File: rtl/txf_store.sv
module txf_store #(
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  input  logic              rd_hi,
  input  logic              rel_en,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [DEPTH-1:0]  occ
);
  logic [WORD_W-1:0] mem [DEPTH];

  // plain write port, no reset, so the array can map to block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // registered read, old data on a same-address write
  always_ff @(posedge clk) begin
    if (rst)
      rd_byte <= '0;
    else if (rd_en)
      rd_byte <= rd_hi ? mem[rd_addr][BYTE_W +: BYTE_W] : mem[rd_addr][0 +: BYTE_W];
  end

  // occupied flags: a completing write wins over a release
  for (genvar g = 0; g < DEPTH; g++) begin : g_occ
    always_ff @(posedge clk) begin
      if (rst)
        occ[g] <= 1'b0;
      else if (wr_en && wr_addr == AW'(g))
        occ[g] <= 1'b1;
      else if (rel_en && rd_addr == AW'(g))
        occ[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/txf_wr_ctrl.sv
module txf_wr_ctrl #(
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr_en,
  input  logic              cpu_wr_word,
  input  logic [WORD_W-1:0] cpu_wr_data,
  input  logic              slot_busy,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [WORD_W-1:0] mem_data
);
  logic [AW-1:0]     wp_q;
  logic              pend_q;
  logic [BYTE_W-1:0] stage_q;
  logic              accept;

  assign accept   = cpu_wr_en && !slot_busy;
  assign mem_addr = wp_q;

  always_comb begin
    mem_we   = 1'b0;
    mem_data = cpu_wr_data;
    if (accept) begin
      if (cpu_wr_word) begin
        mem_we = 1'b1;
      end else if (pend_q) begin
        mem_we   = 1'b1;
        mem_data = {cpu_wr_data[BYTE_W-1:0], stage_q};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q    <= '0;
      pend_q  <= 1'b0;
      stage_q <= '0;
    end else if (accept) begin
      if (cpu_wr_word) begin
        pend_q <= 1'b0;
      end else if (!pend_q) begin
        stage_q <= cpu_wr_data[BYTE_W-1:0];
        pend_q  <= 1'b1;
      end else begin
        pend_q <= 1'b0;
      end
      if (mem_we) wp_q <= wp_q + 1'b1;
    end
  end
endmodule

// File: rtl/txf_rd_ctrl.sv
module txf_rd_ctrl #(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_req,
  input  logic [DEPTH-1:0] occ,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  output logic             rd_hi,
  output logic             rel_en,
  output logic             underrun
);
  logic [AW-1:0] rp_q;
  logic          half_q;

  assign rd_en    = rd_req;
  assign rd_addr  = rp_q;
  assign rd_hi    = half_q;
  assign rel_en   = rd_req && half_q;
  assign underrun = rd_req && !occ[rp_q];

  // no stall on underrun: position moves exactly as for a good read
  always_ff @(posedge clk) begin
    if (rst) begin
      rp_q   <= '0;
      half_q <= 1'b0;
    end else if (rd_req) begin
      half_q <= !half_q;
      if (half_q) rp_q <= rp_q + 1'b1;
    end
  end
endmodule

// File: rtl/txf_irq.sv
module txf_irq
  import txf_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW-1:0]   free_cnt,
  input  logic [1:0]      thr_sel,
  input  logic            underrun,
  input  logic [ST_W-1:0] sts_clr,
  input  logic [ST_W-1:0] irq_mask,
  output logic [ST_W-1:0] sts_q,
  output logic            irq_q
);
  logic [CW-1:0]   need;
  logic            thr_hit;
  logic [ST_W-1:0] set_v;

  assign need    = CW'(thr_words(thr_sel));
  assign thr_hit = free_cnt >= need;

  always_comb begin
    set_v         = '0;
    set_v[ST_THR] = thr_hit;
    set_v[ST_UND] = underrun;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~sts_clr) | set_v;
      irq_q <= |(sts_q & irq_mask);
    end
  end
endmodule

// File: rtl/tx_fifo_uflow.sv
module tx_fifo_uflow
  import txf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr_en,
  input  logic              cpu_wr_word,
  input  logic [WORD_W-1:0] cpu_wr_data,
  input  logic              shf_rd_req,
  output logic [BYTE_W-1:0] shf_byte,
  input  logic [1:0]        thr_sel,
  input  logic [1:0]        irq_mask,
  input  logic [1:0]        sts_clr,
  output logic [1:0]        irq_sts,
  output logic              irq_o,
  output logic              full,
  output logic [CW-1:0]     free_cnt
);
  logic              mem_we;
  logic [AW-1:0]     mem_addr;
  logic [WORD_W-1:0] mem_data;
  logic              rd_en, rd_hi, rel_en, underrun;
  logic [AW-1:0]     rd_addr;
  logic [DEPTH-1:0]  occ;
  logic [CW-1:0]     used;

  always_comb begin
    used = '0;
    for (int i = 0; i < DEPTH; i++) used = used + CW'(occ[i]);
  end

  assign free_cnt = CW'(DEPTH) - used;
  assign full     = occ[mem_addr];

  txf_wr_ctrl #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_wr (
    .clk(clk), .rst(rst), .cpu_wr_en(cpu_wr_en), .cpu_wr_word(cpu_wr_word),
    .cpu_wr_data(cpu_wr_data), .slot_busy(full), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  txf_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst(rst), .rd_req(shf_rd_req), .occ(occ), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_hi(rd_hi), .rel_en(rel_en), .underrun(underrun)
  );

  txf_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(mem_we), .wr_addr(mem_addr), .wr_data(mem_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_hi(rd_hi), .rel_en(rel_en),
    .rd_byte(shf_byte), .occ(occ)
  );

  txf_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst(rst), .free_cnt(free_cnt), .thr_sel(thr_sel),
    .underrun(underrun), .sts_clr(sts_clr), .irq_mask(irq_mask),
    .sts_q(irq_sts), .irq_q(irq_o)
  );
endmodule

// File: rtl/txf_chk.sv
module txf_chk #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_wr_en,
  input logic          shf_rd_req,
  input logic [1:0]    sts_clr,
  input logic [1:0]    irq_mask,
  input logic [1:0]    irq_sts,
  input logic          irq_o,
  input logic          full,
  input logic [CW-1:0] free_cnt
);
  assert_free_bound_R1: assert property (@(posedge clk) disable iff (rst)
    int'(free_cnt) <= DEPTH);

  // occupancy moves by at most one entry per cycle (one write, one release)
  assert_free_step_R2: assert property (@(posedge clk) disable iff (rst)
    1 |=> (int'(free_cnt) <= int'($past(free_cnt)) + 1) &&
          (int'(free_cnt) + 1 >= int'($past(free_cnt))));

  assert_full_drop_R5: assert property (@(posedge clk) disable iff (rst)
    full && cpu_wr_en && !shf_rd_req |=> free_cnt == $past(free_cnt));

  assert_empty_underrun_R7: assert property (@(posedge clk) disable iff (rst)
    shf_rd_req && int'(free_cnt) == DEPTH |=> irq_sts[1]);

  assert_und_clear_R8: assert property (@(posedge clk) disable iff (rst)
    sts_clr[1] && !shf_rd_req |=> !irq_sts[1]);

  assert_und_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    irq_sts[1] && !sts_clr[1] |=> irq_sts[1]);

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
    1 |=> irq_o == $past(|(irq_sts & irq_mask)));
endmodule

bind tx_fifo_uflow txf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cpu_wr_en(cpu_wr_en), .shf_rd_req(shf_rd_req),
  .sts_clr(sts_clr), .irq_mask(irq_mask), .irq_sts(irq_sts), .irq_o(irq_o),
  .full(full), .free_cnt(free_cnt)
);

// File: tb/tx_fifo_uflow_tb.sv
module tx_fifo_uflow_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr_en = 1'b0, cpu_wr_word = 1'b0, shf_rd_req = 1'b0;
  logic [15:0] cpu_wr_data = '0;
  logic [7:0]  shf_byte;
  logic [1:0]  thr_sel = 2'b00, irq_mask = 2'b00, sts_clr = 2'b00, irq_sts;
  logic        irq_o, full;
  logic [3:0]  free_cnt;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference state
  logic [15:0] m_mem [DEPTH];
  bit          m_occ [DEPTH];
  int          m_wp = 0, m_rp = 0;
  bit          m_half = 0, m_pend = 0;
  logic [7:0]  m_stage = '0, m_byte = '0;
  logic [1:0]  m_sts = '0;
  bit          m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_fifo_uflow u_dut (
    .clk(clk), .rst(rst), .cpu_wr_en(cpu_wr_en), .cpu_wr_word(cpu_wr_word),
    .cpu_wr_data(cpu_wr_data), .shf_rd_req(shf_rd_req), .shf_byte(shf_byte),
    .thr_sel(thr_sel), .irq_mask(irq_mask), .sts_clr(sts_clr), .irq_sts(irq_sts),
    .irq_o(irq_o), .full(full), .free_cnt(free_cnt)
  );

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int thr_need(logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  function automatic int m_free();
    int c = DEPTH;
    for (int i = 0; i < DEPTH; i++) if (m_occ[i]) c--;
    return c;
  endfunction

  // one clock: drive at negedge, update the model at the edge, compare after it
  task automatic step(bit wr, bit word, logic [15:0] d, bit rd, logic [1:0] clr);
    int   fo;
    bit   und, was_full;
    cpu_wr_en = wr; cpu_wr_word = word; cpu_wr_data = d; shf_rd_req = rd; sts_clr = clr;
    @(posedge clk);
    fo = m_free();
    was_full = m_occ[m_wp];
    m_irq = |(m_sts & irq_mask);
    und = 0;
    if (rd) begin
      m_byte = m_half ? m_mem[m_rp][15:8] : m_mem[m_rp][7:0];
      und = !m_occ[m_rp];
      if (m_half) begin m_occ[m_rp] = 0; m_rp = (m_rp + 1) % DEPTH; end
      m_half = !m_half;
    end
    if (wr && !was_full) begin
      if (word) begin
        m_mem[m_wp] = d; m_occ[m_wp] = 1; m_wp = (m_wp + 1) % DEPTH; m_pend = 0;
      end else if (!m_pend) begin
        m_stage = d[7:0]; m_pend = 1;
      end else begin
        m_mem[m_wp] = {d[7:0], m_stage}; m_occ[m_wp] = 1; m_wp = (m_wp + 1) % DEPTH; m_pend = 0;
      end
    end
    m_sts = (m_sts & ~clr) | {und, (fo >= thr_need(thr_sel))};
    @(negedge clk);
    chk("R1 free_cnt", free_cnt, m_free());
    chk("R5 full", full, m_occ[m_wp]);
    chk("R8 irq_sts", irq_sts, m_sts);
    chk("R9 irq_o", irq_o, m_irq);
    if (rd) chk("R10 shf_byte", shf_byte, m_byte);
    cpu_wr_en = 0; shf_rd_req = 0; sts_clr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < DEPTH; i++) begin m_mem[i] = '0; m_occ[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 reset free", free_cnt, 8);
    chk("R1 reset full", full, 0);
    chk("R1 reset sts", irq_sts, 0);
    chk("R1 reset irq", irq_o, 0);

    // R2 word write, low byte first
    step(1, 1, 16'hA1B2, 0, 0);  chk("R2 free after word", free_cnt, 7);
    step(0, 0, 0, 1, 0);         chk("R2 low byte", shf_byte, 8'hB2);
    chk("R2 entry held", free_cnt, 7);
    step(0, 0, 0, 1, 0);         chk("R2 high byte", shf_byte, 8'hA1);
    chk("R2 entry released", free_cnt, 8);

    // R3 byte pairing
    step(1, 0, 16'h0011, 0, 0);  chk("R3 half entry not counted", free_cnt, 8);
    step(1, 0, 16'h0022, 0, 0);  chk("R3 pair counted", free_cnt, 7);
    step(0, 0, 0, 1, 0);         chk("R3 first byte low", shf_byte, 8'h11);
    step(0, 0, 0, 1, 0);         chk("R3 second byte high", shf_byte, 8'h22);

    // R4 word after lone byte
    step(1, 0, 16'h0033, 0, 0);
    step(1, 1, 16'h5566, 0, 0);  chk("R4 word stored", free_cnt, 7);
    step(0, 0, 0, 1, 0);         chk("R4 low", shf_byte, 8'h66);
    step(0, 0, 0, 1, 0);         chk("R4 high", shf_byte, 8'h55);
    step(1, 0, 16'h0099, 0, 0);  chk("R4 fresh pair", free_cnt, 8);
    step(1, 0, 16'h00AA, 0, 0);
    step(0, 0, 0, 1, 0);         chk("R4 pair low", shf_byte, 8'h99);
    step(0, 0, 0, 1, 0);         chk("R4 pair high", shf_byte, 8'hAA);

    // R5 fill, drop, drain
    for (int i = 0; i < DEPTH; i++) step(1, 1, 16'h1000 + 16'(i), 0, 0);
    chk("R5 full set", full, 1);
    chk("R5 no free", free_cnt, 0);
    step(1, 1, 16'hDEAD, 0, 0);  chk("R5 dropped word", free_cnt, 0);
    step(1, 0, 16'h00EE, 0, 0);  chk("R5 dropped byte", free_cnt, 0);
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 0, 0, 1, 0);       chk("R5 drain low", shf_byte, i);
      step(0, 0, 0, 1, 0);       chk("R5 drain high", shf_byte, 8'h10);
    end

    // R7 underrun on an empty buffer replays stale data (entry 4 held 0x1000)
    step(0, 0, 0, 0, 2'b11);
    step(0, 0, 0, 1, 0);
    chk("R7 stale byte", shf_byte, 8'h00);
    chk("R7 underrun flag", irq_sts[1], 1);
    step(0, 0, 0, 1, 0);
    chk("R7 stale high", shf_byte, 8'h10);
    chk("R7 no count change", free_cnt, 8);

    // R8 clear by writing one
    step(0, 0, 0, 0, 2'b10);     chk("R8 underrun cleared", irq_sts[1], 0);
    step(0, 0, 0, 0, 2'b00);     chk("R8 stays clear", irq_sts[1], 0);

    // R6 threshold: free = 3
    for (int i = 0; i < 5; i++) step(1, 1, 16'h2000 + 16'(i), 0, 0);
    chk("R6 free three", free_cnt, 3);
    thr_sel = 2'b10;
    step(0, 0, 0, 0, 2'b01);     chk("R6 N=4 not met", irq_sts[0], 0);
    thr_sel = 2'b11;
    step(0, 0, 0, 0, 2'b00);     chk("R6 reserved acts as 4", irq_sts[0], 0);
    thr_sel = 2'b01;
    step(0, 0, 0, 0, 2'b00);     chk("R6 N=2 met", irq_sts[0], 1);
    thr_sel = 2'b00;
    step(0, 0, 0, 0, 2'b01);     chk("R6 N=1 set wins over clear", irq_sts[0], 1);

    // R9 masking
    irq_mask = 2'b01;
    step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    chk("R9 threshold enabled", irq_o, 1);
    irq_mask = 2'b10;
    step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
    chk("R9 masked off", irq_o, 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      thr_sel  = 2'($urandom_range(0, 3));
      irq_mask = 2'($urandom_range(0, 3));
      step(($urandom_range(0, 99) < 50), ($urandom_range(0, 1) == 1),
           16'($urandom), ($urandom_range(0, 99) < 45),
           ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'b00);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule